// File: doc/BRIEF.md
# Asynchronous DRAM Access Controller

This block sits between a simple byte-wide request port and an asynchronous DRAM module whose address pins are shared between row and column. A caller presents a linear address with a read or write flag. The controller splits that address into a row part and a column part, using a width that can be set at runtime. It then runs the active-low row strobe, column strobe and write-enable lines through a fixed sequence. Every phase of that sequence lasts at least a parameterised number of clock cycles. A read returns its byte together with a one-cycle completion pulse.

Refresh uses column-before-row cycles that strobe both row lines at once. A refresh starts either when the caller pulses a refresh input or when an internal interval counter expires. The row/column width and the number of row-strobe banks are loaded at runtime. From those two settings the block derives the module capacity in kilobytes and presents it on an output.

Top module: `adram_ctrl`

## Requirements
- R1: The row address is the linear address shifted right by the configured bit count N and then masked to N bits. The column address is the linear address masked to N bits.
- R2: A configuration load accepts a bit count only in the range 1 to 12 and a bank count only as 1 or 2. Each field is judged on its own, and a rejected field keeps its old value. After reset N is 10 and there is one bank.
- R3: After reset, and whenever busy is low, both row strobes, the column strobe and write enable are high, and the data bus is not driven.
- R4: In an access, the row address is on the pins when the row strobe falls. The column address is on the pins when the column strobe falls, and the row strobe is already low at that point. The row strobe rises before the column strobe rises.
- R5: In a write, the data bus is driven and write enable is low before the row strobe falls. Both are kept until after both strobes have risen.
- R6: In a read, write enable stays high and the bus stays undriven. The byte is sampled while the column strobe is low and is returned on the read-data port in the cycle of the done pulse.
- R7: A refresh drives the column strobe low first, then both row strobes low in the same cycle, then raises the column strobe, then raises both row strobes.
- R8: The capacity output equals 2^(2N) x 4 x (bank count).
- R9: Busy goes high in the cycle after a request is accepted. Busy stays high until the done pulse, which lasts one cycle. A request that arrives while busy is high is ignored.
- R10: A refresh that is pending or requested in the same cycle wins over a new access, and the access is then ignored. A refresh request made during an access waits until that access has finished.
- R11: An interval counter requests a refresh once every REF_INTERVAL cycles without any input.
- R12: Every level of the strobe lines is held for at least PHASE_CYC cycles.
- R13: With two banks, bit 2N of the address selects row strobe 1 (when set) or row strobe 0. With one bank, only row strobe 0 is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cfg_load_i | input | 1 | Load pulse for the configuration fields |
| cfg_bits_i | input | 4 | Requested row/column bit count |
| cfg_banks_i | input | 2 | Requested row-strobe bank count |
| cap_kb_o | output | 28 | Derived capacity in kilobytes |
| req_i | input | 1 | Access request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 25 | Linear byte address |
| req_wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Sequence running or refresh pending |
| done_o | output | 1 | One-cycle access completion pulse |
| rdata_o | output | 8 | Read byte, valid with done |
| ref_req_i | input | 1 | Refresh request pulse |
| dram_addr_o | output | 12 | Multiplexed address pins |
| dram_ras_n_o | output | 2 | Row strobes, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_dq_o | output | 8 | Data bus out value |
| dram_dq_oe_o | output | 1 | Data bus drive enable |
| dram_dq_i | input | 8 | Data bus in value |

## Verification
A refresh request and a new access request can reach the idle sequencer in the same cycle. The bench provokes this by raising both inputs on the same edge. It passes if exactly one column-before-row cycle appears on the strobes, no row/column access is seen by the memory model, and busy then falls without a done pulse. The bench also covers the opposite ordering: it raises the refresh input one cycle after a write is accepted. That write must finish with its data intact in the model, and the refresh must follow it.

// File: rtl/adram_pkg.sv
package adram_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_A_SET,
        ST_A_RAS,
        ST_A_CAD,
        ST_A_CAS,
        ST_A_RREL,
        ST_A_CREL,
        ST_F_CAS,
        ST_F_RAS,
        ST_F_CREL,
        ST_F_END
    } seq_state_e;

    typedef struct packed {
        logic [1:0] ras_n;
        logic       cas_n;
        logic       we_n;
        logic       oe;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{ras_n: 2'b11, cas_n: 1'b1, we_n: 1'b1, oe: 1'b0};

endpackage

// File: rtl/adram_addr_map.sv
module adram_addr_map #(
    parameter int AMAX = 12,
    localparam int LAW  = 2 * AMAX + 1,
    localparam int BW   = $clog2(AMAX + 1),
    localparam int CAPW = 2 * AMAX + 4
) (
    input  logic [LAW-1:0]  lin_addr_i,
    input  logic [BW-1:0]   bits_i,
    input  logic [1:0]      banks_i,
    output logic [AMAX-1:0] row_o,
    output logic [AMAX-1:0] col_o,
    output logic            bank_o,
    output logic [CAPW-1:0] cap_kb_o
);
    logic [LAW-1:0] mask;
    logic [LAW-1:0] shifted;
    logic [LAW-1:0] upper;
    int             cap_shift;

    always_comb begin
        mask      = (LAW'(1) << bits_i) - LAW'(1);
        shifted   = (lin_addr_i >> bits_i) & mask;
        upper     = lin_addr_i >> (2 * int'(bits_i));
        row_o     = shifted[AMAX-1:0];
        col_o     = lin_addr_i[AMAX-1:0] & mask[AMAX-1:0];
        bank_o    = (banks_i == 2'd2) ? upper[0] : 1'b0;
        cap_shift = 2 * int'(bits_i) + 2 + ((banks_i == 2'd2) ? 1 : 0);
        cap_kb_o  = CAPW'(1) << cap_shift;
    end
endmodule

// File: rtl/adram_ref_timer.sv
module adram_ref_timer #(
    parameter int REF_INTERVAL = 400,
    localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    logic [TW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        tick_d = (cnt_q == TW'(REF_INTERVAL - 1));
        cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick_o = tick_q;
endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl
    import adram_pkg::*;
#(
    parameter int AMAX         = 12,
    parameter int DW           = 8,
    parameter int PHASE_CYC    = 2,
    parameter int REF_INTERVAL = 400,
    parameter int BITS_RST     = 10,
    localparam int LAW  = 2 * AMAX + 1,
    localparam int BW   = $clog2(AMAX + 1),
    localparam int CAPW = 2 * AMAX + 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cfg_load_i,
    input  logic [BW-1:0]   cfg_bits_i,
    input  logic [1:0]      cfg_banks_i,
    output logic [CAPW-1:0] cap_kb_o,
    input  logic            req_i,
    input  logic            req_wr_i,
    input  logic [LAW-1:0]  req_addr_i,
    input  logic [DW-1:0]   req_wdata_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [DW-1:0]   rdata_o,
    input  logic            ref_req_i,
    output logic [AMAX-1:0] dram_addr_o,
    output logic [1:0]      dram_ras_n_o,
    output logic            dram_cas_n_o,
    output logic            dram_we_n_o,
    output logic [DW-1:0]   dram_dq_o,
    output logic            dram_dq_oe_o,
    input  logic [DW-1:0]   dram_dq_i
);
    localparam int CNTW = $clog2(PHASE_CYC + 1);

    typedef struct packed {
        seq_state_e      st;
        logic [CNTW-1:0] cnt;
        logic            ref_pend;
        logic            wr;
        logic            bank;
        logic [AMAX-1:0] row;
        logic [AMAX-1:0] col;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   rdata;
        logic            done;
        logic [BW-1:0]   bits;
        logic [1:0]      banks;
        strobe_t         sb;
        logic [AMAX-1:0] addr;
    } ctl_t;

    ctl_t d, q;

    logic [AMAX-1:0] m_row, m_col;
    logic            m_bank;
    logic            tick;
    logic            phase_end;
    seq_state_e      nxt;
    logic [1:0]      bank_ras;
    logic [BW-1:0]   cur_bits;

    assign cur_bits = q.bits;

    adram_addr_map #(.AMAX(AMAX)) u_map (
        .lin_addr_i (req_addr_i),
        .bits_i     (q.bits),
        .banks_i    (q.banks),
        .row_o      (m_row),
        .col_o      (m_col),
        .bank_o     (m_bank),
        .cap_kb_o   (cap_kb_o)
    );

    adram_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.ref_pend = q.ref_pend | ref_req_i | tick;
        phase_end  = (q.cnt == CNTW'(PHASE_CYC - 1));

        if (cfg_load_i) begin
            if (cfg_bits_i >= BW'(1) && cfg_bits_i <= BW'(AMAX)) d.bits = cfg_bits_i;
            if (cfg_banks_i == 2'd1 || cfg_banks_i == 2'd2)      d.banks = cfg_banks_i;
        end

        nxt = q.st;
        unique case (q.st)
            ST_IDLE: begin
                if (q.ref_pend || ref_req_i) begin
                    nxt        = ST_F_CAS;
                    d.ref_pend = tick;
                end else if (req_i) begin
                    nxt     = ST_A_SET;
                    d.wr    = req_wr_i;
                    d.bank  = m_bank;
                    d.row   = m_row;
                    d.col   = m_col;
                    d.wdata = req_wdata_i;
                end
            end
            ST_A_SET:  if (phase_end) nxt = ST_A_RAS;
            ST_A_RAS:  if (phase_end) nxt = ST_A_CAD;
            ST_A_CAD:  if (phase_end) nxt = ST_A_CAS;
            ST_A_CAS: begin
                if (phase_end) begin
                    nxt = ST_A_RREL;
                    if (!q.wr) d.rdata = dram_dq_i;
                end
            end
            ST_A_RREL: if (phase_end) nxt = ST_A_CREL;
            ST_A_CREL: begin
                if (phase_end) begin
                    nxt    = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            ST_F_CAS:  if (phase_end) nxt = ST_F_RAS;
            ST_F_RAS:  if (phase_end) nxt = ST_F_CREL;
            ST_F_CREL: if (phase_end) nxt = ST_F_END;
            ST_F_END:  if (phase_end) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase

        d.st  = nxt;
        d.cnt = (nxt != q.st || nxt == ST_IDLE) ? '0 : q.cnt + 1'b1;

        bank_ras = d.bank ? 2'b01 : 2'b10;
        d.sb     = STROBE_QUIET;
        d.addr   = q.addr;
        unique case (nxt)
            ST_A_SET: begin
                d.addr    = d.row;
                d.sb.we_n = ~d.wr;
                d.sb.oe   = d.wr;
            end
            ST_A_RAS: begin
                d.addr     = d.row;
                d.sb.ras_n = bank_ras;
                d.sb.we_n  = ~d.wr;
                d.sb.oe    = d.wr;
            end
            ST_A_CAD: begin
                d.addr     = d.col;
                d.sb.ras_n = bank_ras;
                d.sb.we_n  = ~d.wr;
                d.sb.oe    = d.wr;
            end
            ST_A_CAS: begin
                d.addr     = d.col;
                d.sb.ras_n = bank_ras;
                d.sb.cas_n = 1'b0;
                d.sb.we_n  = ~d.wr;
                d.sb.oe    = d.wr;
            end
            ST_A_RREL: begin
                d.addr     = d.col;
                d.sb.cas_n = 1'b0;
                d.sb.we_n  = ~d.wr;
                d.sb.oe    = d.wr;
            end
            ST_A_CREL: begin
                d.sb.we_n = ~d.wr;
                d.sb.oe   = d.wr;
            end
            ST_F_CAS:  d.sb.cas_n = 1'b0;
            ST_F_RAS: begin
                d.sb.cas_n = 1'b0;
                d.sb.ras_n = 2'b00;
            end
            ST_F_CREL: d.sb.ras_n = 2'b00;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.bits  <= BW'(BITS_RST);
            q.banks <= 2'd1;
            q.sb    <= STROBE_QUIET;
        end else begin
            q <= d;
        end
    end

    assign busy_o       = (q.st != ST_IDLE) | q.ref_pend;
    assign done_o       = q.done;
    assign rdata_o      = q.rdata;
    assign dram_addr_o  = q.addr;
    assign dram_ras_n_o = q.sb.ras_n;
    assign dram_cas_n_o = q.sb.cas_n;
    assign dram_we_n_o  = q.sb.we_n;
    assign dram_dq_oe_o = q.sb.oe;
    assign dram_dq_o    = q.wdata;
endmodule

// File: rtl/adram_chk.sv
module adram_chk #(
    parameter int AMAX = 12,
    localparam int BW = $clog2(AMAX + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [1:0]    ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          oe,
    input logic          busy,
    input logic          done,
    input logic [BW-1:0] bits
);
    p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy |-> (ras_n == 2'b11 && cas_n && we_n && !oe));

    p_cas_after_ras_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(cas_n) && ras_n != 2'b11) |-> $past(ras_n) != 2'b11);

    p_we_early_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cas_n && !we_n) |-> $past(!we_n));

    p_we_needs_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_n |-> oe);

    p_read_float_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cas_n && we_n) |-> !oe);

    p_cbr_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ras_n == 2'b00 && $past(ras_n) == 2'b11) |-> $past(!cas_n));

    p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done |=> !done);

    p_bits_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bits >= BW'(1) && bits <= BW'(AMAX)));
endmodule

bind adram_ctrl adram_chk #(.AMAX(AMAX)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ras_n  (dram_ras_n_o),
    .cas_n  (dram_cas_n_o),
    .we_n   (dram_we_n_o),
    .oe     (dram_dq_oe_o),
    .busy   (busy_o),
    .done   (done_o),
    .bits   (cur_bits)
);

// File: tb/tb_adram_ctrl.sv
`timescale 1ns/1ps
module tb_adram_ctrl;
    localparam int AMAX = 12;
    localparam int LAW = 2 * AMAX + 1;
    localparam int PHASE = 2;
    localparam int REFI = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [3:0] cfg_bits = '0;
    logic [1:0] cfg_banks = '0;
    logic [27:0] cap_kb;
    logic req = 1'b0, req_wr = 1'b0;
    logic [LAW-1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic busy, done;
    logic [7:0] rdata;
    logic ref_req = 1'b0;
    logic [11:0] d_addr;
    logic [1:0] ras_n;
    logic cas_n, we_n, oe;
    logic [7:0] dq_o, dq_i;

    int total = 0, bad = 0, cyc = 0;
    int cur_bits = 10, cur_banks = 1;

    always #4 clk = ~clk;

    adram_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_bits_i(cfg_bits),
        .cfg_banks_i(cfg_banks), .cap_kb_o(cap_kb), .req_i(req), .req_wr_i(req_wr),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy), .done_o(done),
        .rdata_o(rdata), .ref_req_i(ref_req), .dram_addr_o(d_addr), .dram_ras_n_o(ras_n),
        .dram_cas_n_o(cas_n), .dram_we_n_o(we_n), .dram_dq_o(dq_o), .dram_dq_oe_o(oe),
        .dram_dq_i(dq_i)
    );

    // memory model and protocol observer
    logic [7:0] mem [int unsigned];
    logic [7:0] rd_val = 8'h00;
    int acc_cnt = 0, ref_cnt = 0, ref_bad = 0, order_bad = 0, run_bad = 0;
    int obs_row = 0, obs_col = 0, obs_bank = 0, row_lat = 0, bank_lat = 0, run = 0;
    logic cbr_armed = 1'b0, in_acc = 1'b0, started = 1'b0;
    logic [1:0] p_ras = 2'b11;
    logic p_cas = 1'b1, p_we = 1'b1;

    assign dq_i = (!cas_n && we_n && ras_n != 2'b11) ? rd_val : 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if ({ras_n, cas_n} != {p_ras, p_cas}) begin
                if (started && run < PHASE) run_bad++;
                started = 1'b1;
                run = 1;
            end else run++;
            if (p_ras == 2'b11 && ras_n != 2'b11) begin
                if (p_cas) begin
                    row_lat = int'(d_addr);
                    bank_lat = (ras_n[1] == 1'b0) ? 1 : 0;
                    in_acc = 1'b1;
                    if (!we_n && !oe) order_bad++;
                end else if (cbr_armed) begin
                    if (ras_n == 2'b00) ref_cnt++; else ref_bad++;
                    cbr_armed = 1'b0;
                end
            end
            if (p_cas && !cas_n) begin
                if (p_ras != 2'b11 && ras_n != 2'b11) begin
                    int unsigned key;
                    obs_row = row_lat; obs_col = int'(d_addr); obs_bank = bank_lat;
                    key = (int'(bank_lat) << 24) | (row_lat << 12) | int'(d_addr);
                    acc_cnt++;
                    if (!we_n) mem[key] = dq_o;
                    else rd_val = mem.exists(key) ? mem[key] : 8'hEE;
                end else if (ras_n == 2'b11) cbr_armed = 1'b1;
                else order_bad++;
            end
            if (!p_cas && cas_n && in_acc) begin
                if (ras_n != 2'b11) order_bad++;
                in_acc = 1'b0;
            end
            if (!p_we && we_n && (ras_n != 2'b11 || !cas_n)) order_bad++;
            p_ras = ras_n; p_cas = cas_n; p_we = we_n;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic access(input logic wr, input logic [LAW-1:0] a, input logic [7:0] wd,
                          output logic [7:0] rd);
        wait_idle();
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        rd = 8'hxx;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) begin rd = rdata; break; end
        end
    endtask

    task automatic load_cfg(input int b, input int k);
        @(negedge clk);
        cfg_load = 1'b1; cfg_bits = 4'(b); cfg_banks = 2'(k);
        @(negedge clk);
        cfg_load = 1'b0;
        if (b >= 1 && b <= 12) cur_bits = b;
        if (k == 1 || k == 2) cur_banks = k;
    endtask

    function automatic longint exp_cap();
        return longint'(1) << (2 * cur_bits + 2 + cur_banks - 1);
    endfunction

    task automatic t_reset();
        chk("R3 ras idle", ras_n, 2'b11);
        chk("R3 cas idle", cas_n, 1);
        chk("R3 we idle", we_n, 1);
        chk("R3 oe idle", oe, 0);
        chk("R9 busy idle", busy, 0);
        chk("R8 cap reset", cap_kb, 64'h400000);
    endtask

    task automatic t_config();
        load_cfg(8, 2);
        chk("R8 cap 8/2", cap_kb, 524288);
        load_cfg(0, 2);
        chk("R2 bits 0 rejected", cap_kb, 524288);
        load_cfg(13, 2);
        chk("R2 bits 13 rejected", cap_kb, 524288);
        load_cfg(9, 0);
        chk("R2 banks 0 rejected", cap_kb, 2097152);
        load_cfg(9, 3);
        chk("R2 banks 3 rejected", cap_kb, exp_cap());
        load_cfg(12, 1);
        chk("R8 cap 12/1", cap_kb, 64'h4000000);
    endtask

    task automatic t_split(input int b, input int k, input logic [LAW-1:0] a, input logic [7:0] v);
        logic [7:0] rd;
        longint m;
        int eb;
        load_cfg(b, k);
        m = (longint'(1) << b) - 1;
        eb = (k == 2) ? int'((a >> (2 * b)) & 1) : 0;
        access(1'b1, a, v, rd);
        chk("R1 row", obs_row, (longint'(a) >> b) & m);
        chk("R1 col", obs_col, longint'(a) & m);
        chk("R13 bank", obs_bank, eb);
        access(1'b0, a, 8'h00, rd);
        chk("R6 read back", rd, v);
    endtask

    task automatic t_busy();
        logic [7:0] rd;
        int a0;
        load_cfg(8, 2);
        wait_idle();
        a0 = acc_cnt;
        req = 1'b1; req_wr = 1'b1; req_addr = 25'h00_0210; req_wdata = 8'h5A;
        @(negedge clk);
        req_addr = 25'h00_0321; req_wdata = 8'hC3;
        chk("R9 busy after accept", busy, 1);
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) break;
        end
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R9 one access only", acc_cnt - a0, 1);
        access(1'b0, 25'h00_0321, 8'h00, rd);
        chk("R9 ignored addr untouched", rd, 8'hEE);
        access(1'b0, 25'h00_0210, 8'h00, rd);
        chk("R5 written byte", rd, 8'h5A);
    endtask

    task automatic t_ref_req();
        int r0 = ref_cnt;
        wait_idle();
        ref_req = 1'b1;
        @(negedge clk);
        ref_req = 1'b0;
        wait_idle();
        chk("R7 refresh seen", (ref_cnt - r0) >= 1, 1);
        chk("R7 both rows together", ref_bad, 0);
    endtask

    task automatic t_priority();
        int r0, a0;
        logic [7:0] rd;
        wait_idle();
        r0 = ref_cnt; a0 = acc_cnt;
        req = 1'b1; req_wr = 1'b1; req_addr = 25'h00_0444; req_wdata = 8'h11;
        ref_req = 1'b1;
        @(negedge clk);
        req = 1'b0; ref_req = 1'b0;
        chk("R10 busy from refresh", busy, 1);
        wait_idle();
        chk("R10 refresh won", (ref_cnt - r0) >= 1, 1);
        chk("R10 access dropped", acc_cnt - a0, 0);
        // refresh request arriving during an access waits
        wait_idle();
        r0 = ref_cnt;
        req = 1'b1; req_wr = 1'b1; req_addr = 25'h00_0555; req_wdata = 8'h77;
        @(negedge clk);
        req = 1'b0; ref_req = 1'b1;
        @(negedge clk);
        ref_req = 1'b0;
        wait_idle();
        chk("R10 deferred refresh", (ref_cnt - r0) >= 1, 1);
        access(1'b0, 25'h00_0555, 8'h00, rd);
        chk("R10 access intact", rd, 8'h77);
    endtask

    task automatic t_interval();
        int r0;
        wait_idle();
        r0 = ref_cnt;
        repeat (3 * REFI) @(negedge clk);
        chk("R11 periodic refresh", ((ref_cnt - r0) >= 2) && ((ref_cnt - r0) <= 4), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_split(8, 2, 25'h00_0123, 8'hA5);
        t_split(8, 2, 25'h01_4567, 8'h3C);
        t_split(10, 1, 25'h0F_37A5, 8'h96);
        t_split(12, 2, 25'h1A_BCDE, 8'h0F);
        t_split(1, 1, 25'h00_0003, 8'hE1);
        t_busy();
        t_ref_req();
        t_priority();
        t_interval();
        chk("R4 strobe order", order_bad, 0);
        chk("R12 phase length", run_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule